// File: doc/BRIEF.md
# Coulomb Counter with Snapshot Readout

This block measures battery charge. It adds a stream of signed current-sense samples into a 32-bit charge accumulator and counts those samples in a 24-bit sample counter. A sample is taken once per sample interval. The interval is built from a millisecond prescaler followed by a per-interval millisecond count, and a 2-bit code in the control register selects one of four interval lengths.

Software reaches the block through a byte-wide register port. That port holds a control register, a 14-bit hardware offset and the byte-split charge and sample values. The port allows single-byte accesses only. To keep the multi-byte values coherent, a read of the charge accumulator's lowest byte freezes a copy of both the accumulator and the sample counter. Every later byte read of either value returns that frozen copy.

The block has two further functions:
- **Offset correction.** When enabled, the offset is subtracted from each sample before the sample is accumulated.
- **Calibration.** While calibration runs, samples are counted but add nothing to the accumulator. Their mean is then loaded into the offset register.

Top module: `coulomb_counter`

## Requirements
- R1: After reset, the control register, the offset, the accumulator, the sample counter and `reg_rdata` are all zero.
- R2: While enabled, each sample interval adds the sample to the accumulator and increments the counter once. The interval is `code_ms x CLKS_PER_MS` clock cycles, with the interval code at control bits 5:4: 0 = 15 ms, 1 = 62 ms, 2 = 125 ms, 3 = 250 ms. The first sample falls one full interval after enable.
- R3: Writing the control register (0x60) with bit 1 set zeroes the accumulator and the sample counter. Bit 1 always reads back as 0.
- R4: While the enable bit (control bit 0) is 0, the accumulator and the counter keep their values.
- R5: With control bit 3 set, the signed 14-bit offset is subtracted from each sample before accumulation. The accumulator wraps in 32-bit two's complement.
- R6: A read of 0x66 (accumulator bits 7:0) returns the live byte and copies the accumulator and the counter into shadow registers. Reads of 0x65, 0x64 and 0x63 return shadow accumulator bits 15:8, 23:16 and 31:24. Reads of 0x69, 0x68 and 0x67 return shadow counter bits 7:0, 15:8 and 23:16.
- R7: The offset is 14 bits. Address 0x62 holds bits 7:0. Address 0x61 holds bits 13:8 in its bits 5:0, and bits 7:6 of 0x61 read as 0.
- R8: The control register reads back with bit 0 = enable, bit 2 = calibration running, bit 3 = offset enable and bits 5:4 = interval code. Bits 7:6 and bit 1 read as 0.
- R9: With control bit 2 set and counting enabled, samples are counted but add zero to the accumulator. After 2^CAL_LOG2 samples, the offset becomes the arithmetic-shift mean of those raw samples and bit 2 clears.
- R10: Read data appears one clock after the read strobe. Unmapped addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sense_sample | input | SAMPLE_W | Signed current-sense sample |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_we | input | 1 | Write strobe |
| reg_re | input | 1 | Read strobe |
| reg_rdata | output | 8 | Registered read data |

## Verification
The bench builds the block with CLKS_PER_MS = 2 and CAL_LOG2 = 2. With these values the 15, 62 and 250 ms intervals last 30, 124 and 500 cycles, and a calibration pass takes only four samples. Runs of a known number of samples therefore finish in a few hundred cycles. The exact sample counts tell the interval codes apart, and the snapshot can be checked against a counter that has kept moving after the freeze.

// File: rtl/coulomb_counter.sv
module coulomb_counter #(
  parameter int CLKS_PER_MS = 1000,
  parameter int SAMPLE_W    = 16,
  parameter int CAL_LOG2    = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SAMPLE_W-1:0] sense_sample,
  input  logic [7:0]          reg_addr,
  input  logic [7:0]          reg_wdata,
  input  logic                reg_we,
  input  logic                reg_re,
  output logic [7:0]          reg_rdata
);
  localparam int PRE_W = (CLKS_PER_MS > 1) ? $clog2(CLKS_PER_MS) : 1;
  localparam int CAL_N = 1 << CAL_LOG2;
  localparam int CAL_W = SAMPLE_W + CAL_LOG2;
  localparam logic [PRE_W-1:0] PRE_MAX = PRE_W'(CLKS_PER_MS - 1);
  localparam logic [CAL_LOG2-1:0] CAL_LAST = CAL_LOG2'(CAL_N - 1);

  localparam logic [7:0] A_CTRL   = 8'h60;
  localparam logic [7:0] A_OFF_HI = 8'h61;
  localparam logic [7:0] A_OFF_LO = 8'h62;
  localparam logic [7:0] A_ACC3   = 8'h63;
  localparam logic [7:0] A_ACC2   = 8'h64;
  localparam logic [7:0] A_ACC1   = 8'h65;
  localparam logic [7:0] A_ACC0   = 8'h66;
  localparam logic [7:0] A_CNT2   = 8'h67;
  localparam logic [7:0] A_CNT1   = 8'h68;
  localparam logic [7:0] A_CNT0   = 8'h69;

  logic                       en_q, cal_q, offen_q;
  logic [1:0]                 code_q;
  logic [13:0]                off_q;
  logic [31:0]                acc_q, sh_acc_q;
  logic [23:0]                cnt_q, sh_cnt_q;
  logic [PRE_W-1:0]           pre_q;
  logic [7:0]                 ms_q;
  logic [CAL_LOG2-1:0]        cal_cnt_q;
  logic signed [CAL_W-1:0]    cal_sum_q;

  function automatic logic [7:0] ivl_ms(input logic [1:0] c);
    case (c)
      2'd0:    return 8'd15;
      2'd1:    return 8'd62;
      2'd2:    return 8'd125;
      default: return 8'd250;
    endcase
  endfunction

  logic ctrl_wr, clear_wr, ms_tick, ivl_last, smp_tick;
  assign ctrl_wr  = reg_we && (reg_addr == A_CTRL);
  assign clear_wr = ctrl_wr && reg_wdata[1];
  assign ms_tick  = en_q && (pre_q == PRE_MAX);
  assign ivl_last = ms_q >= (ivl_ms(code_q) - 8'd1);
  assign smp_tick = ms_tick && ivl_last;

  logic signed [31:0]       smp_ext, off_ext, add_val;
  logic signed [CAL_W-1:0]  cal_total, cal_avg;
  assign smp_ext   = 32'(signed'(sense_sample));
  assign off_ext   = 32'(signed'(off_q));
  assign add_val   = cal_q ? 32'sd0 : (offen_q ? smp_ext - off_ext : smp_ext);
  assign cal_total = cal_sum_q + CAL_W'(signed'(sense_sample));
  assign cal_avg   = cal_total >>> CAL_LOG2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      ms_q  <= '0;
    end else if (!en_q || clear_wr) begin
      pre_q <= '0;
      ms_q  <= '0;
    end else if (pre_q == PRE_MAX) begin
      pre_q <= '0;
      ms_q  <= ivl_last ? 8'd0 : ms_q + 8'd1;
    end else begin
      pre_q <= pre_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else if (clear_wr) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else if (smp_tick) begin
      acc_q <= acc_q + add_val;
      cnt_q <= cnt_q + 24'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q      <= 1'b0;
      cal_q     <= 1'b0;
      offen_q   <= 1'b0;
      code_q    <= '0;
      off_q     <= '0;
      cal_cnt_q <= '0;
      cal_sum_q <= '0;
    end else begin
      if (reg_we && reg_addr == A_OFF_HI) off_q[13:8] <= reg_wdata[5:0];
      if (reg_we && reg_addr == A_OFF_LO) off_q[7:0]  <= reg_wdata;
      if (ctrl_wr) begin
        en_q      <= reg_wdata[0];
        cal_q     <= reg_wdata[2];
        offen_q   <= reg_wdata[3];
        code_q    <= reg_wdata[5:4];
        cal_cnt_q <= '0;
        cal_sum_q <= '0;
      end else if (smp_tick && cal_q) begin
        if (cal_cnt_q == CAL_LAST) begin
          cal_q <= 1'b0;
          off_q <= cal_avg[13:0];
        end else begin
          cal_cnt_q <= cal_cnt_q + 1'b1;
          cal_sum_q <= cal_total;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_rdata <= '0;
      sh_acc_q  <= '0;
      sh_cnt_q  <= '0;
    end else if (reg_re) begin
      if (reg_addr == A_ACC0) begin
        sh_acc_q <= acc_q;
        sh_cnt_q <= cnt_q;
      end
      case (reg_addr)
        A_CTRL:   reg_rdata <= {2'b00, code_q, offen_q, cal_q, 1'b0, en_q};
        A_OFF_HI: reg_rdata <= {2'b00, off_q[13:8]};
        A_OFF_LO: reg_rdata <= off_q[7:0];
        A_ACC0:   reg_rdata <= acc_q[7:0];
        A_ACC1:   reg_rdata <= sh_acc_q[15:8];
        A_ACC2:   reg_rdata <= sh_acc_q[23:16];
        A_ACC3:   reg_rdata <= sh_acc_q[31:24];
        A_CNT0:   reg_rdata <= sh_cnt_q[7:0];
        A_CNT1:   reg_rdata <= sh_cnt_q[15:8];
        A_CNT2:   reg_rdata <= sh_cnt_q[23:16];
        default:  reg_rdata <= 8'h00;
      endcase
    end
  end

  assert_clear_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clear_wr |=> (acc_q == 32'd0 && cnt_q == 24'd0));

  assert_hold_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !clear_wr) |=> ($stable(acc_q) && $stable(cnt_q)));

  assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !clear_wr |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 24'd1));

  assert_cal_no_accum_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_q && !clear_wr) |=> $stable(acc_q));

  assert_snapshot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_re && reg_addr == A_ACC0) |=> (sh_acc_q == $past(acc_q) && sh_cnt_q == $past(cnt_q)
                                       && reg_rdata == sh_acc_q[7:0]));

  assert_offhi_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_re && reg_addr == A_OFF_HI) |=> reg_rdata[7:6] == 2'b00);

  assert_ctrl_rsvd_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_re && reg_addr == A_CTRL) |=> (reg_rdata[7:6] == 2'b00 && !reg_rdata[1]));
endmodule

// File: tb/coulomb_counter_bench.sv
module coulomb_counter_bench;
  localparam int CPM = 2;
  localparam int P15 = 15 * CPM, P62 = 62 * CPM, P250 = 250 * CPM;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [15:0] sense_sample = '0;
  logic [7:0]  reg_addr = '0, reg_wdata = '0, reg_rdata;
  logic        reg_we = 1'b0, reg_re = 1'b0;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  coulomb_counter #(.CLKS_PER_MS(CPM), .SAMPLE_W(16), .CAL_LOG2(2)) u_coulomb_counter (
    .clk(clk), .rst_n(rst_n), .sense_sample(sense_sample), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_re(reg_re), .reg_rdata(reg_rdata));

  task automatic check(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got 0x%0h expected 0x%0h", req, what, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(posedge clk); #1;
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_re = 1'b1;
    @(posedge clk); #1;
    reg_re = 1'b0;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic snap(output logic [31:0] acc, output logic [23:0] cnt);
    logic [7:0] b;
    rd(8'h66, b); acc[7:0] = b;
    rd(8'h65, b); acc[15:8] = b;
    rd(8'h64, b); acc[23:16] = b;
    rd(8'h63, b); acc[31:24] = b;
    rd(8'h69, b); cnt[7:0] = b;
    rd(8'h68, b); cnt[15:8] = b;
    rd(8'h67, b); cnt[23:16] = b;
  endtask

  task automatic run(input logic [7:0] ctrl, input int cycles);
    wr(8'h60, ctrl);
    repeat (cycles - 1) @(posedge clk);
    wr(8'h60, {ctrl[7:3], 3'b000});
  endtask

  task automatic t_reset;
    logic [7:0] b; logic [31:0] a; logic [23:0] c;
    check("R1", "rdata at reset", 32'(reg_rdata), 0);
    rd(8'h60, b); check("R1", "ctrl at reset", 32'(b), 0);
    rd(8'h61, b); check("R1", "offset hi at reset", 32'(b), 0);
    rd(8'h62, b); check("R1", "offset lo at reset", 32'(b), 0);
    snap(a, c);
    check("R1", "acc at reset", a, 0);
    check("R1", "cnt at reset", 32'(c), 0);
    rd(8'h70, b); check("R10", "unmapped read", 32'(b), 0);
  endtask

  task automatic t_interval;
    logic [31:0] a; logic [23:0] c;
    sense_sample = 16'd7;
    run(8'h01, 3 * P15);
    snap(a, c);
    check("R2", "code0 count", 32'(c), 3);
    check("R2", "code0 acc", a, 21);
    run(8'h13, 2 * P62);
    snap(a, c);
    check("R2", "code1 count", 32'(c), 2);
    check("R3", "clear with enable, acc", a, 14);
    run(8'h33, P250 - 1);
    snap(a, c);
    check("R2", "code3 short of interval", 32'(c), 0);
    run(8'h33, P250);
    snap(a, c);
    check("R2", "code3 count", 32'(c), 1);
  endtask

  task automatic t_clear_hold;
    logic [7:0] b; logic [31:0] a; logic [23:0] c;
    wr(8'h60, 8'h02);
    rd(8'h60, b); check("R3", "clear bit reads 0", 32'(b), 0);
    rd(8'h60, b); check("R8", "ctrl after clear", 32'(b), 0);
    snap(a, c);
    check("R3", "acc cleared", a, 0);
    check("R3", "cnt cleared", 32'(c), 0);
    sense_sample = 16'd9;
    run(8'h01, P15);
    repeat (200) @(posedge clk);
    snap(a, c);
    check("R4", "acc held while disabled", a, 9);
    check("R4", "cnt held while disabled", 32'(c), 1);
  endtask

  task automatic t_offset_regs;
    logic [7:0] b;
    wr(8'h61, 8'hFF);
    rd(8'h61, b); check("R7", "offset hi masked", 32'(b), 32'h3F);
    wr(8'h61, 8'h00);
    wr(8'h62, 8'h05);
    rd(8'h62, b); check("R7", "offset lo", 32'(b), 5);
    wr(8'h60, 8'h38);
    rd(8'h60, b); check("R8", "ctrl readback", 32'(b), 32'h38);
    wr(8'h60, 8'h00);
  endtask

  task automatic t_offset_and_wrap;
    logic [31:0] a; logic [23:0] c;
    sense_sample = 16'd20;
    run(8'h0B, 3 * P15);
    snap(a, c);
    check("R5", "offset subtracted", a, 45);
    check("R5", "offset count", 32'(c), 3);
    sense_sample = 16'hFFFD;
    run(8'h03, 4 * P15);
    snap(a, c);
    check("R5", "negative wrap", a, 32'hFFFFFFF4);
  endtask

  task automatic t_snapshot;
    logic [7:0] b; logic [31:0] a; logic [23:0] c;
    rd(8'h66, b);
    check("R6", "live lsb", 32'(b), 32'hF4);
    run(8'h01, 2 * P15);
    rd(8'h65, b); check("R6", "shadow acc byte1", 32'(b), 32'hFF);
    rd(8'h63, b); check("R6", "shadow acc byte3", 32'(b), 32'hFF);
    rd(8'h69, b); check("R6", "shadow cnt byte0", 32'(b), 4);
    snap(a, c);
    check("R6", "new snapshot acc", a, 32'hFFFFFFEE);
    check("R6", "new snapshot cnt", 32'(c), 6);
  endtask

  task automatic t_calibrate;
    logic [7:0] b; logic [31:0] a; logic [23:0] c;
    wr(8'h60, 8'h02);
    sense_sample = 16'd6;
    wr(8'h60, 8'h05);
    repeat (4 * P15 - 2) @(posedge clk);
    rd(8'h60, b); check("R9", "cal bit running", 32'(b), 32'h05);
    repeat (5) @(posedge clk);
    rd(8'h60, b); check("R9", "cal bit cleared", 32'(b), 32'h01);
    wr(8'h60, 8'h00);
    rd(8'h62, b); check("R9", "offset lo from cal", 32'(b), 6);
    rd(8'h61, b); check("R9", "offset hi from cal", 32'(b), 0);
    snap(a, c);
    check("R9", "acc unchanged during cal", a, 0);
    check("R9", "samples counted during cal", 32'(c), 4);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_interval();
    t_clear_hold();
    t_offset_regs();
    t_offset_and_wrap();
    t_snapshot();
    t_calibrate();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule